// File: doc/BRIEF.md
# NAND Reset and Identification Sequencer

This block brings a NAND flash device out of power-up and identifies it, using only the shared command/address/data strobes of the flash bus. A single start pulse makes it issue the reset command, wait a settle interval and then poll the device status byte until the device reports that reset has completed. In extended-verification mode the polling is bounded by an overall time budget; otherwise it polls until the device answers.

Once reset has completed, the block runs an identification exchange and reads back five identification bytes. It compares the maker and device codes with the one supported part, decodes the geometry byte, and reports a 2-bit verdict together with the derived pages-per-block count, the lowest address bit of the block and page fields, and the bus width. All intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `nand_boot_probe`

## Requirements
- R1: After reset `done` and all bus strobes are low, and `status` and all geometry outputs read zero.
- R2: A `start` pulse makes the block issue command 0xFF; the first status command 0x70 follows exactly SETTLE_CYC+1 cycles after it (SETTLE_CYC = CLK_MHZ*SETTLE_US), and the status byte is read in the cycle after each 0x70.
- R3: Reset counts as complete only when status bits 5 and 6 are both set; a status byte with only one of them set causes another poll.
- R4: Consecutive status commands are exactly POLL_CYC+2 cycles apart (POLL_CYC = CLK_MHZ*POLL_US).
- R5: With `ext_verify` high at start, if MAX_POLLS+1 status reads (MAX_POLLS = LIMIT_US/POLL_US) all fail, the block ends with `status` = 2'b10 and issues no identification command.
- R6: With `ext_verify` low at start, polling continues with no limit until reset completes.
- R7: Identification is command 0x90, then exactly one address cycle of 0x00, then exactly five data reads.
- R8: If ID byte 0 is not 0x2C or ID byte 1 is not 0xBA, the result is `status` = 2'b01 (part not found), checked before geometry.
- R9: For a known part, ID byte 3 must hold page code bits[1:0] = 01, spare bit 2 = 1 and block code bits[5:4] = 01; otherwise `status` = 2'b10.
- R10: On success `status` = 2'b00, `pages_per_blk` = 64, `blk_addr_lsb` = 17, `pg_addr_lsb` = 11, and `wide_bus` equals ID byte 3 bit 6.
- R11: `done` is high for exactly one cycle per run, and a `start` pulse while a run is in progress is ignored.
- R12: At most one of the bus strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| ext_verify | input | 1 | Bounds status polling by the time budget when high, sampled at start |
| nf_cmd_we | output | 1 | Command byte strobe |
| nf_addr_we | output | 1 | Address byte strobe |
| nf_rd | output | 1 | Data read strobe; `nf_rdata` is taken at the end of this cycle |
| nf_wdata | output | 8 | Command or address byte |
| nf_rdata | input | 8 | Byte returned by the device |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 00 ok, 01 part not found, 10 device error; held until next start |
| pages_per_blk | output | PPB_W | Pages per erase block |
| blk_addr_lsb | output | 5 | Lowest byte-address bit of the block field |
| pg_addr_lsb | output | 5 | Lowest byte-address bit of the page field |
| wide_bus | output | 1 | 1 when the part has a 16-bit data bus |

## Verification
The device model answers status reads with busy bytes that set neither, one or the other of bits 5 and 6, so a design that accepts a single bit is told apart from one that needs both. Ready latencies are drawn on both sides of the poll budget, in both modes, which separates the bounded from the unbounded polling and pins the exact number of reads before a time-out. Identification bytes mix the correct pair, a wrong maker, a wrong device and legal or corrupted geometry bytes with either bus width, so the order of the not-found and geometry checks and each geometry field are exercised alone. Command spacing is timed in every run to catch settle and poll interval errors.

// File: rtl/nbp_pkg.sv
package nbp_pkg;

   typedef enum logic [1:0] {
      NBP_OK       = 2'b00,
      NBP_NOTFOUND = 2'b01,
      NBP_DEVERR   = 2'b10
   } nbp_verdict_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST_CMD,
      ST_SETTLE,
      ST_STAT_CMD,
      ST_STAT_RD,
      ST_POLL_WAIT,
      ST_ID_CMD,
      ST_ID_ADDR,
      ST_ID_RD,
      ST_DECODE,
      ST_FINISH
   } nbp_state_e;

   localparam logic [7:0] NBP_CMD_RESET  = 8'hFF;
   localparam logic [7:0] NBP_CMD_STATUS = 8'h70;
   localparam logic [7:0] NBP_CMD_READID = 8'h90;

   localparam logic [7:0] NBP_SUP_MAKER  = 8'h2C;
   localparam logic [7:0] NBP_SUP_DEVICE = 8'hBA;
   localparam logic [4:0] NBP_BLK_LSB    = 5'd17;
   localparam logic [4:0] NBP_PG_LSB     = 5'd11;

   localparam int NBP_ID_BYTES = 5;

endpackage

// File: rtl/nbp_interval.sv
module nbp_interval #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         expired
);

   logic [W-1:0] cnt;

   generate
      if (W < 1) begin : g_bad_width
         $error("nbp_interval: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= len;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R2 / R4: the interval shrinks by exactly one each cycle until it expires
   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nbp_id_check.sv
module nbp_id_check
   import nbp_pkg::*;
#(
   parameter int PPB_W = 8
) (
   input  logic [7:0]       maker,
   input  logic [7:0]       device,
   input  logic [1:0]       pg_code,
   input  logic             spare_code,
   input  logic [1:0]       blk_code,
   output nbp_verdict_e     verdict,
   output logic [PPB_W-1:0] ppb
);

   generate
      if (PPB_W < 7 || PPB_W > 16) begin : g_bad_ppb
         $error("nbp_id_check: PPB_W must lie in 7..16");
      end
   endgenerate

   logic known_part;
   logic geo_ok;

   assign known_part = (maker == NBP_SUP_MAKER) && (device == NBP_SUP_DEVICE);
   assign geo_ok     = (pg_code == 2'b01) && spare_code && (blk_code == 2'b01);

   // block holds 64 KiB << blk_code, page holds 1 KiB << pg_code
   assign ppb = (PPB_W'(64) << blk_code) >> pg_code;

   always_comb begin
      if (!known_part)  verdict = NBP_NOTFOUND;
      else if (!geo_ok) verdict = NBP_DEVERR;
      else              verdict = NBP_OK;
   end

endmodule

// File: rtl/nand_boot_probe.sv
module nand_boot_probe
   import nbp_pkg::*;
#(
   parameter int CLK_MHZ   = 125,
   parameter int SETTLE_US = 1000,
   parameter int POLL_US   = 50,
   parameter int LIMIT_US  = 1000000,
   parameter int PPB_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ext_verify,
   output logic             nf_cmd_we,
   output logic             nf_addr_we,
   output logic             nf_rd,
   output logic [7:0]       nf_wdata,
   input  logic [7:0]       nf_rdata,
   output logic             done,
   output logic [1:0]       status,
   output logic [PPB_W-1:0] pages_per_blk,
   output logic [4:0]       blk_addr_lsb,
   output logic [4:0]       pg_addr_lsb,
   output logic             wide_bus
);

   localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam int POLL_CYC   = CLK_MHZ * POLL_US;
   localparam int MAX_POLLS  = LIMIT_US / POLL_US;
   localparam int LONGEST    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
   localparam int TW         = $clog2(LONGEST + 1);
   localparam int PW         = $clog2(MAX_POLLS + 1);

   generate
      if (CLK_MHZ < 1 || SETTLE_US < 1 || POLL_US < 1) begin : g_bad_timing
         $error("nand_boot_probe: clock and intervals must be positive");
      end
      if (LIMIT_US < POLL_US) begin : g_bad_limit
         $error("nand_boot_probe: LIMIT_US must cover one poll interval");
      end
   endgenerate

   nbp_state_e   state;
   logic         ext_q;
   logic [PW-1:0] polls_left;
   logic [2:0]   rd_idx;
   logic [7:0]   id_maker, id_device;
   logic [5:0]   id_geo;          // {width, blk[1:0], spare, pg[1:0]}
   nbp_verdict_e stat_q;
   logic [PPB_W-1:0] ppb_q;
   logic [4:0]   blk_lsb_q, pg_lsb_q;
   logic         wide_q;

   logic         tick_load, tick_expired;
   logic [TW-1:0] tick_len;
   nbp_verdict_e verdict;
   logic [PPB_W-1:0] ppb_dec;
   logic         ready_seen;

   // ---------------- interval timer ----------------
   assign tick_load = (state == ST_RST_CMD) || (state == ST_STAT_RD);
   assign tick_len  = (state == ST_RST_CMD) ? TW'(SETTLE_CYC - 1) : TW'(POLL_CYC - 1);

   nbp_interval #(.W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tick_load),
      .len     (tick_len),
      .expired (tick_expired)
   );

   // ---------------- identification decode ----------------
   nbp_id_check #(.PPB_W(PPB_W)) u_idchk (
      .maker      (id_maker),
      .device     (id_device),
      .pg_code    (id_geo[1:0]),
      .spare_code (id_geo[2]),
      .blk_code   (id_geo[4:3]),
      .verdict    (verdict),
      .ppb        (ppb_dec)
   );

   // ---------------- bus strobes ----------------
   assign ready_seen = nf_rdata[6] & nf_rdata[5];
   assign nf_cmd_we  = (state == ST_RST_CMD) || (state == ST_STAT_CMD) || (state == ST_ID_CMD);
   assign nf_addr_we = (state == ST_ID_ADDR);
   assign nf_rd      = (state == ST_STAT_RD) || (state == ST_ID_RD);

   always_comb begin
      case (state)
         ST_RST_CMD:  nf_wdata = NBP_CMD_RESET;
         ST_STAT_CMD: nf_wdata = NBP_CMD_STATUS;
         ST_ID_CMD:   nf_wdata = NBP_CMD_READID;
         default:     nf_wdata = 8'h00;
      endcase
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         ext_q      <= 1'b0;
         polls_left <= '0;
         rd_idx     <= '0;
         id_maker   <= '0;
         id_device  <= '0;
         id_geo     <= '0;
         stat_q     <= NBP_OK;
         ppb_q      <= '0;
         blk_lsb_q  <= '0;
         pg_lsb_q   <= '0;
         wide_q     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               ext_q      <= ext_verify;
               polls_left <= PW'(MAX_POLLS);
               stat_q     <= NBP_OK;
               ppb_q      <= '0;
               blk_lsb_q  <= '0;
               pg_lsb_q   <= '0;
               wide_q     <= 1'b0;
               state      <= ST_RST_CMD;
            end
            ST_RST_CMD:  state <= ST_SETTLE;
            ST_SETTLE:   if (tick_expired) state <= ST_STAT_CMD;
            ST_STAT_CMD: state <= ST_STAT_RD;
            ST_STAT_RD: begin
               if (ready_seen) begin
                  state <= ST_ID_CMD;
               end else if (ext_q && polls_left == '0) begin
                  stat_q <= NBP_DEVERR;
                  state  <= ST_FINISH;
               end else begin
                  if (ext_q) polls_left <= polls_left - 1'b1;
                  state <= ST_POLL_WAIT;
               end
            end
            ST_POLL_WAIT: if (tick_expired) state <= ST_STAT_CMD;
            ST_ID_CMD:    state <= ST_ID_ADDR;
            ST_ID_ADDR: begin
               rd_idx <= '0;
               state  <= ST_ID_RD;
            end
            ST_ID_RD: begin
               case (rd_idx)
                  3'd0:    id_maker  <= nf_rdata;
                  3'd1:    id_device <= nf_rdata;
                  3'd3:    id_geo    <= {nf_rdata[6:4], nf_rdata[2:0]};
                  default: ;
               endcase
               if (rd_idx == 3'(NBP_ID_BYTES - 1)) state <= ST_DECODE;
               else                                rd_idx <= rd_idx + 1'b1;
            end
            ST_DECODE: begin
               stat_q <= verdict;
               if (verdict == NBP_OK) begin
                  ppb_q     <= ppb_dec;
                  blk_lsb_q <= NBP_BLK_LSB;
                  pg_lsb_q  <= NBP_PG_LSB;
                  wide_q    <= id_geo[5];
               end
               state <= ST_FINISH;
            end
            ST_FINISH: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign done          = (state == ST_FINISH);
   assign status        = stat_q;
   assign pages_per_blk = ppb_q;
   assign blk_addr_lsb  = blk_lsb_q;
   assign pg_addr_lsb   = pg_lsb_q;
   assign wide_bus      = wide_q;

   // ---------------- assertions ----------------
   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nf_cmd_we, nf_addr_we, nf_rd}));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_addr_after_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
      nf_addr_we |-> ($past(nf_cmd_we) && $past(nf_wdata) == NBP_CMD_READID && nf_wdata == 8'h00));

   assert_ok_geometry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == NBP_OK) |-> (pages_per_blk == PPB_W'(64) &&
                                      blk_addr_lsb == 5'd17 && pg_addr_lsb == 5'd11));

   assert_stat_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nf_cmd_we && nf_wdata == NBP_CMD_STATUS) |=> nf_rd);

endmodule

// File: tb/test_nand_boot_probe.sv
module test_nand_boot_probe;

   localparam int CLK_MHZ   = 1;
   localparam int SETTLE_US = 20;
   localparam int POLL_US   = 5;
   localparam int LIMIT_US  = 100;
   localparam int PPB_W     = 8;
   localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam int POLL_CYC   = CLK_MHZ * POLL_US;
   localparam int MAX_POLLS  = LIMIT_US / POLL_US;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ext_verify = 1'b0;
   logic nf_cmd_we, nf_addr_we, nf_rd;
   logic [7:0] nf_wdata;
   logic [7:0] nf_rdata = 8'h00;
   logic done;
   logic [1:0] status;
   logic [PPB_W-1:0] pages_per_blk;
   logic [4:0] blk_addr_lsb, pg_addr_lsb;
   logic wide_bus;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // device model state
   int   ready_after = 0;
   int   busy_style  = 0;
   logic [7:0] id_bytes [5];
   logic [7:0] cur_cmd = 8'h00;
   int   n_reset, n_stat_cmd, n_stat_rd, n_id_cmd, n_addr, n_id_rd, n_addr_bad;
   int   rst_cyc, last_stat_cyc, first_gap, gap_bad;

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc <= cyc + 1;

   nand_boot_probe #(
      .CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US), .POLL_US(POLL_US),
      .LIMIT_US(LIMIT_US), .PPB_W(PPB_W)
   ) i_nand_boot_probe (
      .clk(clk), .rst_n(rst_n), .start(start), .ext_verify(ext_verify),
      .nf_cmd_we(nf_cmd_we), .nf_addr_we(nf_addr_we), .nf_rd(nf_rd),
      .nf_wdata(nf_wdata), .nf_rdata(nf_rdata), .done(done), .status(status),
      .pages_per_blk(pages_per_blk), .blk_addr_lsb(blk_addr_lsb),
      .pg_addr_lsb(pg_addr_lsb), .wide_bus(wide_bus)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] busy_byte(input int k);
      logic [7:0] r;
      r = 8'($urandom()) & 8'h9F;
      case (busy_style)
         1:       return (k % 2 == 0) ? (r | 8'h20) : (r | 8'h40);
         default: return r | ((k % 3 == 0) ? 8'h00 : (k % 3 == 1 ? 8'h20 : 8'h40));
      endcase
   endfunction

   function automatic int exp_verdict(input logic [7:0] m, input logic [7:0] d, input logic [7:0] g);
      if (m != 8'h2C || d != 8'hBA) return 1;
      if (g[1:0] != 2'b01 || !g[2] || g[5:4] != 2'b01) return 2;
      return 0;
   endfunction

   // device model: reacts to strobes between edges
   initial begin
      forever begin
         @(negedge clk);
         if (nf_cmd_we) begin
            cur_cmd = nf_wdata;
            if (nf_wdata == 8'hFF) begin
               n_reset++;
               rst_cyc = cyc;
            end else if (nf_wdata == 8'h70) begin
               if (n_stat_cmd == 0) first_gap = cyc - rst_cyc;
               else if (cyc - last_stat_cyc != POLL_CYC + 2) gap_bad++;
               last_stat_cyc = cyc;
               n_stat_cmd++;
            end else if (nf_wdata == 8'h90) begin
               n_id_cmd++;
            end
         end
         if (nf_addr_we) begin
            n_addr++;
            if (nf_wdata != 8'h00 || cur_cmd != 8'h90) n_addr_bad++;
         end
         if (nf_rd) begin
            if (cur_cmd == 8'h70) begin
               nf_rdata = (n_stat_rd >= ready_after) ? (8'($urandom()) | 8'h60)
                                                     : busy_byte(n_stat_rd);
               n_stat_rd++;
            end else if (cur_cmd == 8'h90 && n_id_rd < 5) begin
               nf_rdata = id_bytes[n_id_rd];
               n_id_rd++;
            end else begin
               nf_rdata = 8'hEE;
               n_id_rd++;
            end
         end
      end
   end

   // watchdog
   initial begin
      wait (cyc > 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic run_trial(input logic ext, input int rdy, input int style,
                            input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3,
                            input logic [7:0] b4, input logic restart_midway);
      int wait_cnt;
      int ev;
      logic timed_out;
      ready_after = rdy;
      busy_style  = style;
      id_bytes[0] = b0; id_bytes[1] = b1; id_bytes[2] = b2;
      id_bytes[3] = b3; id_bytes[4] = b4;
      n_reset = 0; n_stat_cmd = 0; n_stat_rd = 0; n_id_cmd = 0;
      n_addr = 0; n_id_rd = 0; n_addr_bad = 0; gap_bad = 0; first_gap = -1;
      cur_cmd = 8'h00;
      @(negedge clk);
      ext_verify = ext;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ext_verify = ~ext;     // must not matter after start
      if (restart_midway) begin
         repeat (6) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_cnt = 0;
      while (!done && wait_cnt < 20000) begin
         @(negedge clk);
         wait_cnt++;
      end
      chk("R11 run ends with done", int'(done), 1);
      timed_out = ext && (rdy > MAX_POLLS);
      ev = timed_out ? 2 : exp_verdict(b0, b1, b3);
      chk("R2 single reset command", n_reset, 1);
      chk("R2 settle gap", first_gap, SETTLE_CYC + 1);
      chk("R4 poll spacing errors", gap_bad, 0);
      if (timed_out) begin
         chk("R5 status reads before time-out", n_stat_rd, MAX_POLLS + 1);
         chk("R5 time-out verdict", int'(status), 2);
         chk("R5 no identification", n_id_cmd, 0);
      end else begin
         chk("R3 R6 status reads until ready", n_stat_rd, rdy + 1);
         chk("R7 one id command", n_id_cmd, 1);
         chk("R7 one zero address", n_addr, 1);
         chk("R7 address value", n_addr_bad, 0);
         chk("R7 five id reads", n_id_rd, 5);
         if (ev == 1)      chk("R8 not-found verdict", int'(status), 1);
         else if (ev == 2) chk("R9 geometry verdict", int'(status), 2);
         else begin
            chk("R10 ok verdict", int'(status), 0);
            chk("R10 pages per block", int'(pages_per_blk), 64);
            chk("R10 block lsb", int'(blk_addr_lsb), 17);
            chk("R10 page lsb", int'(pg_addr_lsb), 11);
            chk("R10 bus width", int'(wide_bus), int'(b3[6]));
         end
      end
      if (ev != 0) chk("R10 geometry cleared on failure", int'(pages_per_blk), 0);
      @(negedge clk);
      chk("R11 done pulse one cycle", int'(done), 0);
      chk("R11 status held", int'(status), ev);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 done low", int'(done), 0);
      chk("R1 strobes low", int'({nf_cmd_we, nf_addr_we, nf_rd}), 0);
      chk("R1 status zero", int'(status), 0);
      chk("R1 geometry zero", int'({pages_per_blk, blk_addr_lsb, pg_addr_lsb, wide_bus}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", int'({nf_cmd_we, nf_addr_we, nf_rd, done}), 0);

      // directed: immediate ready, x8 part
      run_trial(1'b0, 0, 0, 8'h2C, 8'hBA, 8'h10, 8'h15, 8'h00, 1'b0);
      // R3: busy bytes carrying one of bits 5/6 only, x16 part
      run_trial(1'b0, 4, 1, 8'h2C, 8'hBA, 8'h00, 8'h55, 8'h44, 1'b0);
      // R5: time-out exactly at the budget edge and just inside it
      run_trial(1'b1, MAX_POLLS + 1, 0, 8'h2C, 8'hBA, 8'h00, 8'h15, 8'h00, 1'b0);
      run_trial(1'b1, MAX_POLLS, 1, 8'h2C, 8'hBA, 8'h00, 8'h15, 8'h00, 1'b0);
      // R6: far beyond the budget without extended mode
      run_trial(1'b0, MAX_POLLS + 15, 1, 8'h2C, 8'hBA, 8'h00, 8'h95, 8'h00, 1'b0);
      // R8: wrong maker, wrong device, wrong both with bad geometry
      run_trial(1'b0, 1, 0, 8'hEC, 8'hBA, 8'h00, 8'h15, 8'h00, 1'b0);
      run_trial(1'b0, 1, 0, 8'h2C, 8'hDA, 8'h00, 8'h15, 8'h00, 1'b0);
      run_trial(1'b1, 2, 0, 8'h98, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
      // R9: each geometry field wrong alone
      run_trial(1'b0, 0, 0, 8'h2C, 8'hBA, 8'h00, 8'h16, 8'h00, 1'b0);
      run_trial(1'b0, 0, 0, 8'h2C, 8'hBA, 8'h00, 8'h11, 8'h00, 1'b0);
      run_trial(1'b0, 0, 0, 8'h2C, 8'hBA, 8'h00, 8'h25, 8'h00, 1'b0);
      // R11: restart request during a run is ignored
      run_trial(1'b0, 2, 0, 8'h2C, 8'hBA, 8'h00, 8'h15, 8'h00, 1'b1);

      // constrained random trials
      for (int t = 0; t < 40; t++) begin
         logic [7:0] m, d, g;
         int sel;
         sel = int'($urandom_range(0, 9));
         m = (sel < 7) ? 8'h2C : 8'($urandom());
         d = (sel < 6 || sel == 9) ? 8'hBA : 8'($urandom());
         g = ($urandom_range(0, 1) == 0) ? ((8'($urandom()) & 8'hC8) | 8'h15) : 8'($urandom());
         run_trial(1'($urandom_range(0, 1)), int'($urandom_range(0, MAX_POLLS + 4)),
                   int'($urandom_range(0, 1)), m, d, 8'($urandom()), g, 8'($urandom()), 1'b0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule